// File: doc/BRIEF.md
# Two-Channel Bus Watchpoint Unit

This block is a debug watchpoint comparator with two channels, A and B. Each channel observes two buses at once: the CPU's local bus, which carries virtual addresses tagged with an address-space identifier, and a shared internal bus, which carries physical addresses from every master on it, including the DMA controller. A channel fires when a bus cycle matches its programmed address (under a don't-care mask), its address-space identifier (local bus only), its bus/cycle-type/direction qualifier and, for channel B only, an optional masked data value.

Every match sets a sticky flag for that channel and bus. Software clears a flag by writing 0 to it. Matches from both channels in the same cycle merge into a single break request pulse to the CPU, while both channels' flags are still recorded. Channel B can be pointed at the X/Y memory cycles carried on the local bus. When it is, its matches are reported in its local-bus flag.

All settings go through a small register port. Writes to the address, mask, identifier and data registers take effect on the next cycle. A channel stays inert until its qualifier register holds three non-zero groups. Both buses are treated alike whichever master issued the cycle, so the block has no master filter.

Top module: `bus_watchpoint`

## Requirements
- R1: A channel compares the whole bus address with its address register. Address bits set to 1 in the channel's mask register are excluded from the compare.
- R2: On local-bus cycles a channel also requires `lb_asid` to equal its identifier register. Internal-bus cycles carry no identifier and skip this compare.
- R3: Qualifier bit 7 enables a data compare on channel B. The bus data must then equal the data register (offset 8) on every bit that is 0 in the data mask register (offset 9). On channel A, bit 7 is stored as 0 and has no effect.
- R4: The qualifier register holds three 2-bit groups. Bits [1:0] select the bus: bit 0 is local, bit 1 is internal. Bits [3:2] select the cycle type: bit 2 is instruction fetch, bit 3 is data access. Bits [5:4] select the direction: bit 4 is read, bit 5 is write. A channel whose qualifier has any group equal to 00 never matches. After reset every qualifier is 0.
- R5: The flag register (offset 10) holds one bit per channel and bus. Bit 0 is A/local, bit 1 is A/internal, bit 2 is B/local, bit 3 is B/internal. A match sets its flag at the clock edge that ends the matching cycle.
- R6: Flags are sticky. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R7: Qualifier bit 6 on channel B makes it watch local-bus cycles with `lb_xy`=1 in place of ordinary local cycles. Such a match sets flag bit 2. Channel A never matches a cycle with `lb_xy`=1, and on channel A bit 6 is stored as 0.
- R8: `brk_req` is high for exactly the one cycle after each cycle in which at least one channel matched. It is a single pulse even when both channels match, and both channels' flags are set.
- R9: An internal-bus instruction fetch is matched with address bits [1:0] ignored, because such fetches appear rounded down to a longword. Internal data cycles and local cycles compare those bits.
- R10: The register offsets are 0 to 3 for channel A (address, mask, identifier, qualifier) and 4 to 7 for channel B in the same order. Each reads back what was written, and a new address, mask or identifier applies from the next cycle without rewriting the qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| lb_valid | input | 1 | Local-bus cycle present |
| lb_addr | input | 32 | Local-bus virtual address |
| lb_asid | input | 8 | Local-bus address-space identifier |
| lb_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| lb_write | input | 1 | 1 = write, 0 = read |
| lb_xy | input | 1 | Cycle belongs to X/Y memory |
| lb_data | input | 32 | Local-bus data |
| ib_valid | input | 1 | Internal-bus cycle present (any master) |
| ib_addr | input | 32 | Internal-bus physical address |
| ib_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| ib_write | input | 1 | 1 = write, 0 = read |
| ib_data | input | 32 | Internal-bus data |
| brk_req | output | 1 | Merged break request pulse |

## Verification
The assertions assume that bus qualifier inputs are meaningful only while the matching valid is high. They also assume that a flag can change only through a bus match or a write to offset 10, so a stable flag is expected whenever neither occurs. The stimulus drives each bus cycle for exactly one clock with its valid, and returns valid to 0 before the next. Register writes are issued between bus cycles, except in the one deliberate collision test that checks set-over-clear priority. Qualifier values are swept across all 64 combinations of the three groups, so the disabled-channel property is exercised both with and without activity on the buses.

// File: rtl/bwp_pkg.sv
// Package: shared types and register offsets for the bus watchpoint unit.
// Assumes a 4-bit register offset space.
package bwp_pkg;
    typedef struct packed {
        logic       data_en;  // channel B only: require data compare
        logic       xy_sel;   // channel B only: watch X/Y cycles
        logic [1:0] dir;      // [0] read, [1] write
        logic [1:0] cyc;      // [0] fetch, [1] data
        logic [1:0] bus;      // [0] local, [1] internal
    } qual_t;

    localparam logic [3:0] OFS_ADDR  = 4'd0;
    localparam logic [3:0] OFS_MASK  = 4'd1;
    localparam logic [3:0] OFS_ASID  = 4'd2;
    localparam logic [3:0] OFS_QUAL  = 4'd3;
    localparam logic [3:0] OFS_DATA  = 4'd8;
    localparam logic [3:0] OFS_DMASK = 4'd9;
    localparam logic [3:0] OFS_FLAGS = 4'd10;
    localparam int         NCH       = 2;
endpackage

// File: rtl/bwp_regs.sv
// Module: configuration registers and sticky match flags.
// Per-channel blocks sit at offset ch*4, followed by the shared data/mask
// and flag registers. Assumes AW, DW, IW and 8 are no wider than RW.
module bwp_regs
    import bwp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int IW = 8,
    parameter int RW = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [3:0]            reg_ofs,
    input  logic [RW-1:0]         wr_data,
    output logic [RW-1:0]         rd_data,
    input  logic [2*NCH-1:0]      hit_vec,
    output logic [NCH-1:0][AW-1:0] addr_cfg,
    output logic [NCH-1:0][AW-1:0] mask_cfg,
    output logic [NCH-1:0][IW-1:0] asid_cfg,
    output qual_t [NCH-1:0]       qual_cfg,
    output logic [DW-1:0]         data_cfg,
    output logic [DW-1:0]         dmask_cfg,
    output logic [2*NCH-1:0]      flag_vec
);
    localparam int FW = 2 * NCH;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam logic [1:0] CHB = 2'(ch);
        // Per-channel address, mask, identifier and qualifier storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_cfg[ch] <= '0;
                mask_cfg[ch] <= '0;
                asid_cfg[ch] <= '0;
                qual_cfg[ch] <= '0;
            end else if (wr_en && reg_ofs[3:2] == CHB) begin
                case (reg_ofs[1:0])
                    2'd0: addr_cfg[ch] <= wr_data[AW-1:0];
                    2'd1: mask_cfg[ch] <= wr_data[AW-1:0];
                    2'd2: asid_cfg[ch] <= wr_data[IW-1:0];
                    default: qual_cfg[ch] <= (ch == 0) ? qual_t'({2'b00, wr_data[5:0]})
                                                       : qual_t'(wr_data[7:0]);
                endcase
            end
        end
    end

    // Channel B data value and data mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_cfg  <= '0;
            dmask_cfg <= '0;
        end else if (wr_en && reg_ofs == OFS_DATA) begin
            data_cfg  <= wr_data[DW-1:0];
        end else if (wr_en && reg_ofs == OFS_DMASK) begin
            dmask_cfg <= wr_data[DW-1:0];
        end
    end

    // Sticky flags: software may only clear, matches set with priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_vec <= '0;
        end else if (wr_en && reg_ofs == OFS_FLAGS) begin
            flag_vec <= (flag_vec & wr_data[FW-1:0]) | hit_vec;
        end else begin
            flag_vec <= flag_vec | hit_vec;
        end
    end

    // Combinational readback, zero-extended to RW.
    always_comb begin
        rd_data = '0;
        case (reg_ofs)
            4'd0:      rd_data[AW-1:0] = addr_cfg[0];
            4'd1:      rd_data[AW-1:0] = mask_cfg[0];
            4'd2:      rd_data[IW-1:0] = asid_cfg[0];
            4'd3:      rd_data[7:0]    = qual_cfg[0];
            4'd4:      rd_data[AW-1:0] = addr_cfg[1];
            4'd5:      rd_data[AW-1:0] = mask_cfg[1];
            4'd6:      rd_data[IW-1:0] = asid_cfg[1];
            4'd7:      rd_data[7:0]    = qual_cfg[1];
            OFS_DATA:  rd_data[DW-1:0] = data_cfg;
            OFS_DMASK: rd_data[DW-1:0] = dmask_cfg;
            OFS_FLAGS: rd_data[FW-1:0] = flag_vec;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bwp_chan.sv
// Module: one watchpoint channel comparing both buses against its settings.
// HAS_DATA adds the masked data compare, HAS_XY lets the channel watch X/Y
// cycles. Outputs are combinational hits for the current bus cycle.
module bwp_chan
    import bwp_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int IW       = 8,
    parameter bit HAS_DATA = 1'b0,
    parameter bit HAS_XY   = 1'b0
) (
    input  logic [AW-1:0] addr_cfg,
    input  logic [AW-1:0] mask_cfg,
    input  logic [IW-1:0] asid_cfg,
    input  qual_t         qual_cfg,
    input  logic [DW-1:0] data_cfg,
    input  logic [DW-1:0] dmask_cfg,
    input  logic          lb_valid,
    input  logic [AW-1:0] lb_addr,
    input  logic [IW-1:0] lb_asid,
    input  logic          lb_fetch,
    input  logic          lb_write,
    input  logic          lb_xy,
    input  logic [DW-1:0] lb_data,
    input  logic          ib_valid,
    input  logic [AW-1:0] ib_addr,
    input  logic          ib_fetch,
    input  logic          ib_write,
    input  logic [DW-1:0] ib_data,
    output logic          lb_hit,
    output logic          ib_hit
);
    logic [AW-1:0] ib_mask;
    logic          lb_kind_ok, ib_kind_ok, lb_port_ok;
    logic          lb_data_ok, ib_data_ok;

    // Cycle-type and direction qualification for each bus.
    always_comb begin
        lb_kind_ok = (lb_fetch ? qual_cfg.cyc[0] : qual_cfg.cyc[1])
                   & (lb_write ? qual_cfg.dir[1] : qual_cfg.dir[0]);
        ib_kind_ok = (ib_fetch ? qual_cfg.cyc[0] : qual_cfg.cyc[1])
                   & (ib_write ? qual_cfg.dir[1] : qual_cfg.dir[0]);
        lb_port_ok = HAS_XY ? (qual_cfg.xy_sel == lb_xy) : !lb_xy;
    end

    // Masked data compare, forced true when absent or disabled.
    always_comb begin
        lb_data_ok = !HAS_DATA || !qual_cfg.data_en
                   || (((lb_data ^ data_cfg) & ~dmask_cfg) == '0);
        ib_data_ok = !HAS_DATA || !qual_cfg.data_en
                   || (((ib_data ^ data_cfg) & ~dmask_cfg) == '0);
    end

    // Final hit per bus; internal fetches ignore the two low address bits.
    always_comb begin
        ib_mask    = mask_cfg;
        ib_mask[1:0] = mask_cfg[1:0] | {2{ib_fetch}};
        lb_hit = lb_valid && qual_cfg.bus[0] && lb_port_ok && lb_kind_ok
              && (((lb_addr ^ addr_cfg) & ~mask_cfg) == '0)
              && (lb_asid == asid_cfg) && lb_data_ok;
        ib_hit = ib_valid && qual_cfg.bus[1] && ib_kind_ok
              && (((ib_addr ^ addr_cfg) & ~ib_mask) == '0) && ib_data_ok;
    end
endmodule

// File: rtl/bus_watchpoint.sv
// Module: top of the two-channel bus watchpoint unit.
// Channel 0 (A) is address-only, channel 1 (B) adds data and X/Y watch.
// Hits from both channels merge into one registered break request.
module bus_watchpoint
    import bwp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int IW = 8,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          lb_valid,
    input  logic [AW-1:0] lb_addr,
    input  logic [IW-1:0] lb_asid,
    input  logic          lb_fetch,
    input  logic          lb_write,
    input  logic          lb_xy,
    input  logic [DW-1:0] lb_data,
    input  logic          ib_valid,
    input  logic [AW-1:0] ib_addr,
    input  logic          ib_fetch,
    input  logic          ib_write,
    input  logic [DW-1:0] ib_data,
    output logic          brk_req
);
    logic [NCH-1:0][AW-1:0] addr_cfg, mask_cfg;
    logic [NCH-1:0][IW-1:0] asid_cfg;
    qual_t [NCH-1:0]        qual_cfg;
    logic [DW-1:0]          data_cfg, dmask_cfg;
    logic [2*NCH-1:0]       hit_vec, flag_vec;

    bwp_regs #(.AW(AW), .DW(DW), .IW(IW), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .reg_ofs(reg_addr),
        .wr_data(reg_wdata), .rd_data(reg_rdata), .hit_vec(hit_vec),
        .addr_cfg(addr_cfg), .mask_cfg(mask_cfg), .asid_cfg(asid_cfg),
        .qual_cfg(qual_cfg), .data_cfg(data_cfg), .dmask_cfg(dmask_cfg),
        .flag_vec(flag_vec)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        bwp_chan #(
            .AW(AW), .DW(DW), .IW(IW),
            .HAS_DATA(ch == 1), .HAS_XY(ch == 1)
        ) u_chan (
            .addr_cfg(addr_cfg[ch]), .mask_cfg(mask_cfg[ch]),
            .asid_cfg(asid_cfg[ch]), .qual_cfg(qual_cfg[ch]),
            .data_cfg(data_cfg), .dmask_cfg(dmask_cfg),
            .lb_valid(lb_valid), .lb_addr(lb_addr), .lb_asid(lb_asid),
            .lb_fetch(lb_fetch), .lb_write(lb_write), .lb_xy(lb_xy),
            .lb_data(lb_data),
            .ib_valid(ib_valid), .ib_addr(ib_addr), .ib_fetch(ib_fetch),
            .ib_write(ib_write), .ib_data(ib_data),
            .lb_hit(hit_vec[2*ch]), .ib_hit(hit_vec[2*ch+1])
        );
    end

    // Merged break request: one pulse per cycle holding any hit.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_req <= 1'b0;
        else        brk_req <= |hit_vec;
    end
endmodule

// File: rtl/bwp_check.sv
// Module: assertion checker for bus_watchpoint, attached by bind below.
// Assumes flag bit order A/local, A/internal, B/local, B/internal.
module bwp_check #(
    parameter int RW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic [RW-1:0] reg_wdata,
    input logic          lb_valid,
    input logic          ib_valid,
    input logic          brk_req,
    input logic [3:0]    flag_vec,
    input logic [7:0]    qual_a
);
    logic a_off;
    logic flag_wr;
    assign a_off   = (qual_a[1:0] == 2'b00) || (qual_a[3:2] == 2'b00) || (qual_a[5:4] == 2'b00);
    assign flag_wr = reg_wr && (reg_addr == 4'd10);

    // A request is always accompanied by a recorded flag.
    p_req_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (flag_vec != 4'b0));

    // No bus activity means no request in the next cycle.
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lb_valid && !ib_valid) |=> !brk_req);

    // Internal-bus flags only rise from internal-bus cycles.
    p_ib_src_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_vec[1] && !ib_valid) |=> !flag_vec[1]);
    p_ib_src_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_vec[3] && !ib_valid) |=> !flag_vec[3]);

    // A channel with a zero qualifier group records nothing.
    p_disabled_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_off && flag_vec[1:0] == 2'b00) |=> (flag_vec[1:0] == 2'b00));

    // Flags persist unless software writes 0 to them.
    for (genvar i = 0; i < 4; i++) begin : g_sticky
        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_vec[i] && !(flag_wr && !reg_wdata[i])) |=> flag_vec[i]);
    end
endmodule

bind bus_watchpoint bwp_check #(.RW(RW)) u_bwp_check (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .lb_valid(lb_valid), .ib_valid(ib_valid),
    .brk_req(brk_req), .flag_vec(flag_vec), .qual_a(qual_cfg[0])
);

// File: tb/bus_watchpoint_bench.sv
// Bench: sweeps qualifiers, mask bits and corner cases of bus_watchpoint,
// computing every expected value from the requirement encodings.
module bus_watchpoint_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd10;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lb_valid = 0, lb_fetch = 0, lb_write = 0, lb_xy = 0;
    logic [31:0] lb_addr = '0, lb_data = '0;
    logic [7:0]  lb_asid = '0;
    logic        ib_valid = 0, ib_fetch = 0, ib_write = 0;
    logic [31:0] ib_addr = '0, ib_data = '0;
    logic        brk_req;

    int n_run = 0;
    int n_fail = 0;
    logic       s_req;
    logic [3:0] s_flg;

    always #10 clk = ~clk;

    bus_watchpoint u_bus_watchpoint (.*);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 4'd10;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 4'd10;
    endtask

    // One bus cycle; samples the request and flags in the following cycle.
    task automatic cyc(input bit on_ib, input logic [31:0] a, input logic [7:0] id,
                       input bit f, input bit w, input logic [31:0] d, input bit xy);
        @(negedge clk);
        if (on_ib) begin
            ib_valid = 1; ib_addr = a; ib_fetch = f; ib_write = w; ib_data = d;
        end else begin
            lb_valid = 1; lb_addr = a; lb_asid = id; lb_fetch = f; lb_write = w;
            lb_data = d; lb_xy = xy;
        end
        @(negedge clk);
        lb_valid = 0; ib_valid = 0; lb_xy = 0;
        reg_addr = 4'd10;
        #1 s_req = brk_req; s_flg = reg_rdata[3:0];
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic        e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 reset brk_req", {31'b0, brk_req}, 0);
        rd(4'd3, r); check("R4 reset qualifier A", r, 0);
        rd(4'd10, r); check("R5 reset flags", r, 0);

        // R10 register readback
        wr(4'd0, 32'h1234_5678); rd(4'd0, r); check("R10 readback addr A", r, 32'h1234_5678);
        wr(4'd3, 32'hFF); rd(4'd3, r); check("R10 qual A bits 7:6 read 0", r, 32'h3F);
        wr(4'd7, 32'hFF); rd(4'd7, r); check("R10 qual B full readback", r, 32'hFF);
        wr(4'd7, 0); wr(4'd3, 0);

        // R4/R5 sweep over every qualifier value on channel A
        wr(4'd0, 32'h1000); wr(4'd1, 0); wr(4'd2, 5);
        for (int q = 0; q < 64; q++) begin
            wr(4'd3, q);
            for (int k = 0; k < 8; k++) begin
                bit ib = k[2], f = k[1], w = k[0];
                e = (ib ? q[1] : q[0]) & (f ? q[2] : q[3]) & (w ? q[5] : q[4]);
                cyc(ib, 32'h1000, 8'd5, f, w, 0, 0);
                check("R4 qualifier sweep req", {31'b0, s_req}, {31'b0, e});
                check("R5 flag position", {28'b0, s_flg}, {28'b0, e ? (ib ? 4'b0010 : 4'b0001) : 4'b0000});
                if (e) wr(4'd10, 0);
            end
        end

        // R1 mask sweep on every address bit
        wr(4'd3, 32'h3F);
        for (int i = 0; i < 32; i++) begin
            wr(4'd1, 0);
            cyc(0, 32'h1000 ^ (32'h1 << i), 8'd5, 0, 0, 0, 0);
            check("R1 unmasked bit mismatch", {31'b0, s_req}, 0);
            wr(4'd1, 32'h1 << i);
            cyc(0, 32'h1000 ^ (32'h1 << i), 8'd5, 0, 0, 0, 0);
            check("R1 masked bit ignored", {31'b0, s_req}, 1);
            wr(4'd10, 0);
        end
        wr(4'd1, 0);

        // R2 identifier compare
        cyc(0, 32'h1000, 8'd6, 0, 0, 0, 0);
        check("R2 wrong ASID local", {28'b0, s_flg}, 0);
        cyc(1, 32'h1000, 8'd6, 0, 0, 0, 0);
        check("R2 internal ignores ASID", {28'b0, s_flg}, 32'h2);
        wr(4'd10, 0);

        // R9 rounded internal fetch
        wr(4'd0, 32'h1003);
        cyc(1, 32'h1000, 0, 1, 0, 0, 0);
        check("R9 internal fetch rounded", {28'b0, s_flg}, 32'h2);
        wr(4'd10, 0);
        cyc(1, 32'h1000, 0, 0, 0, 0, 0);
        check("R9 internal data exact", {31'b0, s_req}, 0);
        cyc(0, 32'h1000, 8'd5, 1, 0, 0, 0);
        check("R9 local fetch exact", {31'b0, s_req}, 0);

        // R10 immediate effect of address write
        wr(4'd0, 32'h5550);
        cyc(0, 32'h5550, 8'd5, 0, 1, 0, 0);
        check("R10 new address applies", {28'b0, s_flg}, 32'h1);
        wr(4'd10, 0);
        wr(4'd3, 0);

        // R3 channel B data compare
        wr(4'd4, 32'h2000); wr(4'd5, 0); wr(4'd6, 8'd9);
        wr(4'd8, 32'hCAFE_0000); wr(4'd9, 32'h0000_FFFF); wr(4'd7, 32'hBF);
        cyc(0, 32'h2000, 8'd9, 0, 1, 32'hCAFE_1234, 0);
        check("R3 data match masked", {28'b0, s_flg}, 32'h4);
        wr(4'd10, 0);
        cyc(1, 32'h2000, 0, 0, 1, 32'hCAFF_0000, 0);
        check("R3 data mismatch", {31'b0, s_req}, 0);
        wr(4'd7, 32'h3F);
        cyc(1, 32'h2000, 0, 0, 1, 32'hCAFF_0000, 0);
        check("R3 data compare off", {28'b0, s_flg}, 32'h8);
        wr(4'd10, 0);

        // R7 X/Y watch on channel B
        wr(4'd7, 32'h7F);
        cyc(0, 32'h2000, 8'd9, 0, 0, 0, 1);
        check("R7 XY match on B local flag", {28'b0, s_flg}, 32'h4);
        wr(4'd10, 0);
        cyc(0, 32'h2000, 8'd9, 0, 0, 0, 0);
        check("R7 ordinary cycle ignored", {31'b0, s_req}, 0);
        wr(4'd7, 0);
        wr(4'd0, 32'h2000); wr(4'd2, 8'd9); wr(4'd3, 32'h3F);
        cyc(0, 32'h2000, 8'd9, 0, 0, 0, 1);
        check("R7 channel A ignores XY", {31'b0, s_req}, 0);

        // R8 merged request from both channels
        wr(4'd7, 32'h3F);
        cyc(0, 32'h2000, 8'd9, 0, 0, 0, 0);
        check("R8 merged request", {31'b0, s_req}, 1);
        check("R8 both flags set", {28'b0, s_flg}, 32'h5);
        @(negedge clk); #1;
        check("R8 single pulse", {31'b0, brk_req}, 0);

        // R6 sticky behaviour
        repeat (4) @(negedge clk);
        rd(4'd10, r); check("R6 flags hold", r, 32'h5);
        wr(4'd10, 32'hF); rd(4'd10, r); check("R6 write 1 no effect", r, 32'h5);
        wr(4'd10, 32'hE); rd(4'd10, r); check("R6 clear bit 0 only", r, 32'h4);
        @(negedge clk);
        reg_wr = 1; reg_addr = 4'd10; reg_wdata = 0;
        lb_valid = 1; lb_addr = 32'h2000; lb_asid = 8'd9; lb_fetch = 0; lb_write = 0;
        @(negedge clk);
        reg_wr = 0; lb_valid = 0;
        #1 check("R6 match wins over clear", {28'b0, reg_rdata[3:0]}, 32'h5);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule